// File: doc/BRIEF.md
# Descriptor-Ring Audio Playback DMA

This block feeds several audio playback channels from memory. Software places a ring of period descriptors in memory for each channel. Each descriptor is two 32-bit words: the byte address of one period of samples, then a word whose upper halfword holds that period's length in bytes. Once a channel's start bit is set, the block reads the current descriptor and then streams the period's words into that channel's sample FIFO. It then moves on to the next descriptor and returns to the first entry after the last one. The block flags an interrupt each time a whole period has been delivered.

All channels share one memory read port. That port carries single-word requests with a valid/ready handshake, and only one read is outstanding at a time. Channels that have work are served in round-robin order. A channel asks for data only while its FIFO has room. Software reads the descriptor offset and the byte offset inside the current period to find the playback position.

Top module: `pdl_play_dma`

## Requirements
- R1: After reset every register reads zero, no memory request is pending, no FIFO holds samples and `irq` is low.
- R2: When a channel starts, it first reads the word at base+offset (period address), then base+offset+4 (period length in bits [31:16]). Only after both reads does it read any sample word of that period.
- R3: Sample words are read one 32-bit word at a time from consecutive addresses starting at the period address. They enter that channel's FIFO in address order, and the period-offset register equals the number of bytes accepted so far in the current period.
- R4: When a period's last word is accepted, the descriptor offset grows by 8 and the period offset returns to 0. The descriptor offset returns to 0 instead once the entry at the offset held in size-register bits [31:16] has completed.
- R5: Status bit n is set once for each period that channel n completes, and is not set part-way through a period. The bit stays set until software writes 1 to it (writing 0 leaves it unchanged).
- R6: `irq` is high exactly while some status bit is set and its enable bit is also set.
- R7: When a channel's start bit is cleared, the channel stops fetching, its descriptor and period offsets read 0, its FIFO empties, and any reply still in flight for it is discarded. A later start begins again at descriptor 0.
- R8: While a channel's FIFO is full, no sample read is issued for that channel and its position is held. Fetching resumes from the same place once space frees up.
- R9: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready`, and no new request is issued before the reply to the previous one.
- R10: Register map (word index on `reg_addr`). For channel i: 4i = list base, 4i+1 = list size (bits [31:16]), 4i+2 = descriptor offset (read-only, bits [15:0]), 4i+3 = period offset (read-only, bits [15:0]). At 4·NCH: start bits [NCH-1:0]. At 4·NCH+1: status, with bit n for channel n. At 4·NCH+2: interrupt enable, with bit n for channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read reply valid |
| mem_rsp_data | input | 32 | Read reply word |
| smp_pop | input | NCH | Per-channel FIFO pop |
| smp_avail | output | NCH | Per-channel FIFO not empty |
| smp_data | output | 32·NCH | Per-channel FIFO head word |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume three things about the memory side. It replies only after it has accepted a request. It gives exactly one reply per accepted request. It never asserts a reply in the cycle the request is accepted. The bench's memory model respects all three: it holds each reply until the cycle after acceptance and stretches some requests by withholding ready, which exercises the hold rule. The checks also assume that descriptor lengths are nonzero multiples of 4. The stimulus uses 16- and 32-byte periods and writes the list size before setting a start bit.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  localparam int WORD_W = 32;
  localparam int WORD_B = WORD_W / 8;
  localparam int DESC_B = 2 * WORD_B;

  typedef enum logic [1:0] {
    CH_DESC_A = 2'd0,
    CH_DESC_S = 2'd1,
    CH_DATA   = 2'd2
  } ch_state_t;

  typedef enum logic [1:0] {
    E_IDLE = 2'd0,
    E_REQ  = 2'd1,
    E_WAIT = 2'd2
  } eng_state_t;
endpackage

// File: rtl/pdl_fifo.sv
module pdl_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign dout  = mem[rd_q];

  always_comb begin
    do_push = push && !full && !flush;
    do_pop  = pop && !empty && !flush;
    wr_n    = wr_q;
    rd_n    = rd_q;
    cnt_n   = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_n = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop) cnt_n = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/pdl_chan.sv
module pdl_chan
  import pdl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [31:0] base,
  input  logic [15:0] last,
  input  logic        fifo_full,
  input  logic        rsp_hit,
  input  logic [31:0] rsp_data,
  output logic        need,
  output logic [31:0] req_addr,
  output logic        push,
  output logic        period_done,
  output logic [15:0] list_ptr,
  output logic [15:0] period_ptr
);
  ch_state_t   st_q, st_n;
  logic [15:0] lptr_q, lptr_n, pptr_q, pptr_n, psize_q, psize_n;
  logic [31:0] paddr_q, paddr_n;

  assign list_ptr   = lptr_q;
  assign period_ptr = pptr_q;
  assign need       = run && ((st_q != CH_DATA) || !fifo_full);
  assign push       = rsp_hit && (st_q == CH_DATA);
  assign period_done = push &&
                       (({1'b0, pptr_q} + 17'(WORD_B)) >= {1'b0, psize_q});

  always_comb begin
    case (st_q)
      CH_DESC_A: req_addr = base + {16'h0, lptr_q};
      CH_DESC_S: req_addr = base + {16'h0, lptr_q} + 32'(WORD_B);
      default:   req_addr = paddr_q + {16'h0, pptr_q};
    endcase
  end

  always_comb begin
    st_n    = st_q;
    lptr_n  = lptr_q;
    pptr_n  = pptr_q;
    psize_n = psize_q;
    paddr_n = paddr_q;
    if (!run) begin
      st_n   = CH_DESC_A;
      lptr_n = '0;
      pptr_n = '0;
    end else if (rsp_hit) begin
      case (st_q)
        CH_DESC_A: begin
          paddr_n = rsp_data;
          st_n    = CH_DESC_S;
        end
        CH_DESC_S: begin
          psize_n = rsp_data[31:16];
          pptr_n  = '0;
          st_n    = CH_DATA;
        end
        default: begin
          if (period_done) begin
            pptr_n = '0;
            lptr_n = (lptr_q >= last) ? '0 : lptr_q + 16'(DESC_B);
            st_n   = CH_DESC_A;
          end else begin
            pptr_n = pptr_q + 16'(WORD_B);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CH_DESC_A;
      lptr_q  <= '0;
      pptr_q  <= '0;
      psize_q <= '0;
      paddr_q <= '0;
    end else begin
      st_q    <= st_n;
      lptr_q  <= lptr_n;
      pptr_q  <= pptr_n;
      psize_q <= psize_n;
      paddr_q <= paddr_n;
    end
  end
endmodule

// File: rtl/pdl_rr_arb.sv
module pdl_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q, last_n;
  logic          found;

  always_comb begin
    found   = 1'b0;
    gnt_idx = last_q;
    for (int k = 1; k <= N; k++) begin
      if (!found && req[(int'(last_q) + k) % N]) begin
        found   = 1'b1;
        gnt_idx = IW'((int'(last_q) + k) % N);
      end
    end
    last_n = adv ? gnt_idx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_n;
  end
endmodule

// File: rtl/pdl_play_dma.sv
module pdl_play_dma
  import pdl_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int RA_W = $clog2(NCH * 4 + 4)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [31:0]         mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [31:0]         mem_rsp_data,
  input  logic [NCH-1:0]      smp_pop,
  output logic [NCH-1:0]      smp_avail,
  output logic [NCH*32-1:0]   smp_data,
  output logic                irq
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [RA_W-1:0] A_CTRL = RA_W'(NCH * 4);
  localparam logic [RA_W-1:0] A_STAT = RA_W'(NCH * 4 + 1);
  localparam logic [RA_W-1:0] A_IEN  = RA_W'(NCH * 4 + 2);

  logic [NCH-1:0][31:0] base_q, base_n, req_addr_a;
  logic [NCH-1:0][15:0] last_q, last_n, lptr_a, pptr_a;
  logic [NCH-1:0]       run_q, run_n, stat_q, stat_n, ien_q, ien_n, clr;
  logic [NCH-1:0]       need_v, push_v, done_v, hit_v, full_v, empty_v;

  eng_state_t      eng_q, eng_n;
  logic [CH_W-1:0] cur_q, cur_n, gnt;
  logic [31:0]     addr_q, addr_n;
  logic            abort_q, abort_n, arb_adv;

  // per-channel sequencer and sample FIFO
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit_v[i] = (eng_q == E_WAIT) && mem_rsp_valid && (cur_q == CH_W'(i))
                      && !abort_q && run_q[i];

    pdl_chan u_chan (
      .clk(clk), .rst_n(rst_n), .run(run_q[i]), .base(base_q[i]),
      .last(last_q[i]), .fifo_full(full_v[i]), .rsp_hit(hit_v[i]),
      .rsp_data(mem_rsp_data), .need(need_v[i]), .req_addr(req_addr_a[i]),
      .push(push_v[i]), .period_done(done_v[i]), .list_ptr(lptr_a[i]),
      .period_ptr(pptr_a[i])
    );

    pdl_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(!run_q[i]), .push(push_v[i]),
      .din(mem_rsp_data), .pop(smp_pop[i]), .dout(smp_data[i*32 +: 32]),
      .empty(empty_v[i]), .full(full_v[i])
    );

    assign smp_avail[i] = !empty_v[i];
  end

  assign arb_adv = (eng_q == E_IDLE) && (|need_v);

  pdl_rr_arb #(.N(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(need_v), .adv(arb_adv), .gnt_idx(gnt)
  );

  // shared request engine: one read in flight at a time
  always_comb begin
    eng_n   = eng_q;
    cur_n   = cur_q;
    addr_n  = addr_q;
    abort_n = abort_q;
    case (eng_q)
      E_IDLE: if (arb_adv) begin
        cur_n   = gnt;
        addr_n  = req_addr_a[gnt];
        abort_n = 1'b0;
        eng_n   = E_REQ;
      end
      E_REQ:   if (mem_req_ready) eng_n = E_WAIT;
      default: if (mem_rsp_valid) eng_n = E_IDLE;
    endcase
    if ((eng_q != E_IDLE) && !run_q[cur_q]) abort_n = 1'b1;
  end

  assign mem_req_valid = (eng_q == E_REQ);
  assign mem_req_addr  = addr_q;

  // register writes
  always_comb begin
    base_n = base_q;
    last_n = last_q;
    run_n  = run_q;
    ien_n  = ien_q;
    clr    = '0;
    if (reg_wr) begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr == RA_W'(4 * i))     base_n[i] = reg_wdata;
        if (reg_addr == RA_W'(4 * i + 1)) last_n[i] = reg_wdata[31:16];
      end
      if (reg_addr == A_CTRL) run_n = reg_wdata[NCH-1:0];
      if (reg_addr == A_IEN)  ien_n = reg_wdata[NCH-1:0];
      if (reg_addr == A_STAT) clr   = reg_wdata[NCH-1:0];
    end
    stat_n = (stat_q & ~clr) | done_v;
  end

  // register reads
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == RA_W'(4 * i))     reg_rdata = base_q[i];
      if (reg_addr == RA_W'(4 * i + 1)) reg_rdata = {last_q[i], 16'h0};
      if (reg_addr == RA_W'(4 * i + 2)) reg_rdata = {16'h0, lptr_a[i]};
      if (reg_addr == RA_W'(4 * i + 3)) reg_rdata = {16'h0, pptr_a[i]};
    end
    if (reg_addr == A_CTRL) reg_rdata = 32'(run_q);
    if (reg_addr == A_STAT) reg_rdata = 32'(stat_q);
    if (reg_addr == A_IEN)  reg_rdata = 32'(ien_q);
  end

  assign irq = |(stat_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      last_q  <= '0;
      run_q   <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
      eng_q   <= E_IDLE;
      cur_q   <= '0;
      addr_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      base_q  <= base_n;
      last_q  <= last_n;
      run_q   <= run_n;
      stat_q  <= stat_n;
      ien_q   <= ien_n;
      eng_q   <= eng_n;
      cur_q   <= cur_n;
      addr_q  <= addr_n;
      abort_q <= abort_n;
    end
  end
endmodule

// File: rtl/pdl_play_dma_chk.sv
module pdl_play_dma_chk #(
  parameter int NCH        = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int RA_W = $clog2(NCH * 4 + 4)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [RA_W-1:0]      reg_addr,
  input logic [31:0]          reg_wdata,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic [31:0]          mem_req_addr,
  input logic [NCH-1:0]       run_q,
  input logic [NCH-1:0]       stat_q,
  input logic [NCH-1:0][15:0] lptr_a,
  input logic [NCH-1:0][15:0] pptr_a,
  input logic [NCH-1:0]       full_v,
  input logic [NCH-1:0]       push_v
);
  localparam logic [RA_W-1:0] A_STAT = RA_W'(NCH * 4 + 1);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[i] |=> (lptr_a[i] == 16'h0 && pptr_a[i] == 16'h0)); // R7

    AST_LIST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (lptr_a[i] != $past(lptr_a[i])) |->
        (lptr_a[i] == 16'h0 || lptr_a[i] == $past(lptr_a[i]) + 16'd8)); // R4

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q[i]) |-> $past(reg_wr && reg_addr == A_STAT && reg_wdata[i])); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_v[i] |-> !full_v[i]); // R8
  end
endmodule

bind pdl_play_dma pdl_play_dma_chk #(.NCH(NCH), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .run_q(run_q), .stat_q(stat_q), .lptr_a(lptr_a), .pptr_a(pptr_a),
  .full_v(full_v), .push_v(push_v)
);

// File: tb/pdl_play_dma_test.sv
module pdl_play_dma_test;
  localparam int NCH = 4;
  localparam int RA_W = $clog2(NCH * 4 + 4);
  localparam int A_CTRL = 16, A_STAT = 17, A_IEN = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [RA_W-1:0]   reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0]       mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [31:0]       mem_rsp_data = '0;
  logic [NCH-1:0]    smp_pop = '0;
  logic [NCH-1:0]    smp_avail;
  logic [NCH*32-1:0] smp_data;
  logic              irq;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] q0[$], q1[$];
  bit dr0 = 0, dr1 = 0;
  logic [31:0] req_log[8];
  int nreq = 0, hold_cnt = 0, holds = 0, hold_bad = 0, lat = 0;
  bit pend = 0, seen_v = 0;
  logic [31:0] paddr = '0, seen_a = '0;

  always #4 clk = ~clk;

  pdl_play_dma #(.NCH(NCH), .FIFO_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .smp_pop(smp_pop), .smp_avail(smp_avail), .smp_data(smp_data), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory image: descriptor rings below 0x10000, samples above
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int c, k;
    if (a < 32'h0001_0000) begin
      c = int'(a[15:12]) - 1;
      k = int'(a[11:3]);
      if (a[2]) return {16'(16 * (c + 1)), 16'h0};
      return 32'h0010_0000 + 32'(c) * 32'h1_0000 + 32'(k) * 32'h100;
    end
    return {a[15:0], a[31:16]} ^ 32'hA5A5_5A5A;
  endfunction

  // driver side of the scoreboard
  task automatic expect_period(input int c, input int k);
    logic [31:0] b;
    b = 32'h0010_0000 + 32'(c) * 32'h1_0000 + 32'(k) * 32'h100;
    for (int w = 0; w < 4 * (c + 1); w++) begin
      if (c == 0) q0.push_back(mem_word(b + 32'(4 * w)));
      else        q1.push_back(mem_word(b + 32'(4 * w)));
    end
  endtask

  // memory model
  always @(negedge clk) begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    if (!rst_n) begin
      pend = 0;
    end else if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(paddr);
        pend = 0;
      end else lat--;
    end else if (mem_req_valid) begin
      if (hold_cnt == 0) begin
        mem_req_ready = 1'b1;
        pend = 1;
        paddr = mem_req_addr;
        if (nreq < 8) req_log[nreq] = mem_req_addr;
        nreq++;
        lat = nreq % 3;
        hold_cnt = nreq % 2;
        seen_v = 0;
      end else begin
        if (seen_v && mem_req_addr != seen_a) hold_bad++;
        seen_a = mem_req_addr;
        seen_v = 1;
        holds++;
        hold_cnt--;
      end
    end
  end

  // monitor side of the scoreboard
  always @(negedge clk) begin
    logic [31:0] e;
    smp_pop = '0;
    if (rst_n) begin
      if (dr0 && smp_avail[0] && q0.size() > 0) begin
        e = q0.pop_front();
        check(smp_data[31:0] == e, "R3 ch0 sample order", smp_data[31:0], e);
        smp_pop[0] = 1'b1;
      end
      if (dr1 && smp_avail[1] && q1.size() > 0) begin
        e = q1.pop_front();
        check(smp_data[63:32] == e, "R3 ch1 sample order", smp_data[63:32], e);
        smp_pop[1] = 1'b1;
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = RA_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = RA_W'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_drain(input int c);
    for (int t = 0; t < 20000; t++) begin
      if ((c == 0 ? q0.size() : q1.size()) == 0) break;
      @(negedge clk);
    end
    repeat (80) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit allz;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    allz = 1;
    for (int a = 0; a < A_IEN + 1; a++) begin
      rd(a, d);
      if (d != 0) allz = 0;
    end
    check(allz, "R1 registers zero after reset", 32'(allz), 32'h1);
    check(!irq && !mem_req_valid && smp_avail == 0, "R1 outputs idle",
          {29'h0, irq, mem_req_valid, |smp_avail}, 32'h0);

    // R10: channel 0 ring of 4 entries, readback of size field
    wr(0, 32'h0000_1000);
    wr(1, 32'h0018_0000);
    rd(1, d);
    check(d == 32'h0018_0000, "R10 list size readback", d, 32'h0018_0000);
    rd(0, d);
    check(d == 32'h0000_1000, "R10 list base readback", d, 32'h0000_1000);

    for (int p = 0; p < 6; p++) expect_period(0, p % 4);
    dr0 = 1;
    wr(A_CTRL, 32'h1);
    wait_drain(0);
    // R2: descriptor then length then samples
    check(req_log[0] == 32'h1000, "R2 first read is period address", req_log[0], 32'h1000);
    check(req_log[1] == 32'h1004, "R2 second read is length word", req_log[1], 32'h1004);
    check(req_log[2] == 32'h0010_0000, "R2 then first sample", req_log[2], 32'h0010_0000);
    check(req_log[3] == 32'h0010_0004, "R3 consecutive sample", req_log[3], 32'h0010_0004);
    check(q0.size() == 0, "R3 ch0 all samples delivered", 32'(q0.size()), 32'h0);
    // R4: seven periods done, now in entry 3 with FIFO full
    rd(2, d);
    check(d == 32'h18, "R4 descriptor offset after wrap", d, 32'h18);
    rd(3, d);
    check(d == 32'h0, "R4 period offset reset at boundary", d, 32'h0);
    rd(A_STAT, d);
    check(d == 32'h1, "R5 ch0 period status", d, 32'h1);
    check(irq == 1'b0, "R6 irq low while disabled", 32'(irq), 32'h0);

    // R8: channel 1, 32-byte periods, no draining
    wr(4, 32'h0000_2000);
    wr(5, 32'h0008_0000);
    wr(A_CTRL, 32'h3);
    repeat (100) @(negedge clk);
    rd(7, d);
    check(d == 32'd16, "R8 position held while FIFO full", d, 32'd16);
    rd(A_STAT, d);
    check(d[1] == 1'b0, "R5 no status mid-period", 32'(d[1]), 32'h0);
    check(smp_avail[1] == 1'b1, "R8 samples waiting", 32'(smp_avail[1]), 32'h1);
    expect_period(1, 0);
    expect_period(1, 1);
    expect_period(1, 0);
    dr1 = 1;
    wait_drain(1);
    check(q1.size() == 0, "R8 ch1 resumed after stall", 32'(q1.size()), 32'h0);
    rd(A_STAT, d);
    check(d == 32'h3, "R5 both status bits set", d, 32'h3);
    wr(A_STAT, 32'h2);
    rd(A_STAT, d);
    check(d == 32'h1, "R5 write-one clears only its bit", d, 32'h1);
    wr(A_IEN, 32'h1);
    check(irq == 1'b1, "R6 irq with enabled status", 32'(irq), 32'h1);
    wr(A_IEN, 32'h2);
    check(irq == 1'b0, "R6 irq off when enabled bit clear", 32'(irq), 32'h0);

    // R7: stop channel 1
    wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    rd(6, d);
    check(d == 32'h0, "R7 descriptor offset cleared", d, 32'h0);
    rd(7, d);
    check(d == 32'h0, "R7 period offset cleared", d, 32'h0);
    check(smp_avail[1] == 1'b0, "R7 FIFO flushed", 32'(smp_avail[1]), 32'h0);
    expect_period(1, 0);
    wr(A_CTRL, 32'h3);
    wait_drain(1);
    check(q1.size() == 0, "R7 restart from entry 0", 32'(q1.size()), 32'h0);
    rd(6, d);
    check(d == 32'h8, "R7 offset after first period on restart", d, 32'h8);

    check(hold_bad == 0 && holds > 0, "R9 address stable until ready",
          32'(hold_bad), 32'h0);
    done = 1;
    summary();
    $finish;
  end
endmodule